// File: doc/BRIEF.md
# Message-Signaled Interrupt File Core

This block keeps the interrupt state of one message-signaled interrupt file. The file is split into several independent pages, typically one for the host and one for each guest. Each page holds a pending bit and an enable bit for every interrupt identity, plus a one-bit delivery switch and a threshold. An incoming message names a page and an identity and marks that identity pending. Software reaches each page's registers through a small select/word/mask interface. All writes are read-modify-write under a bit mask.

For each page the core continuously finds the top interrupt. This is the lowest-numbered identity, counting from 1, that is both pending and enabled and that is allowed through by the threshold. The core drives the page's external interrupt line when delivery is on and a top interrupt exists. Writing the top-interrupt register claims the interrupt: it clears the pending bit of the current top identity. Address decoding, privilege checks and the bus front end sit outside this block.

Top module: `msi_file_core`

## Requirements
- R1: After reset, every pending bit, enable bit, delivery bit and threshold of every page is zero, every top-interrupt value reads 0 and every `ext_irq` bit is low.
- R2: A set-pending request (`setp_valid`) with `setp_id` in the range 1 to NUM_IDS-1 sets that identity's pending bit in page `setp_page` at the next clock edge. Identity 0, identities of NUM_IDS or more, and pages of NUM_PAGES or more are ignored.
- R3: The top-interrupt value (select code 2) is the lowest identity of 1 or more that is both pending and enabled and eligible under R4. That identity appears in bits [26:16] and again in bits [10:0], and all other bits are zero. When no identity qualifies, the value is 0.
- R4: When a page's threshold is nonzero and at most NUM_IDS, only identities strictly below the threshold are eligible. When the threshold is zero or greater than NUM_IDS, every identity is eligible.
- R5: A register write to select code 2 with a nonzero write mask ignores the write data. It clears the pending bit of the identity that is top at that moment. With no top interrupt, or with a zero mask, it changes nothing.
- R6: The delivery register (select code 0) has only bit 0 writable. Its other bits read as zero.
- R7: The threshold register (select code 1) is writable only in bits [10:0]. Its other bits read as zero.
- R8: `ext_irq[p]` is high exactly when page p's delivery bit is set and its top-interrupt value is nonzero. It follows state changes from the clock edge that makes them, with no extra delay.
- R9: Pending words (select code 3) and enable words (select code 4) hold 32 identities each; word w, bit b stands for identity 32*w+b. Writes set each masked bit to the written data bit and leave unmasked bits alone. Bit 0 of word 0 (identity 0) always reads zero and cannot be written.
- R10: `reg_rdata` shows, in the same cycle, the current value of the register that page, select and word address. So a read during a write returns the value from before the write. Unused select codes, words past the end and pages of NUM_PAGES or more read 0 and ignore writes.
- R11: When a set-pending request and a register write hit the same page in one cycle, the register write is applied first and the set-pending afterwards. The set identity therefore ends up pending.
- R12: Pages are independent: a write or set-pending on one page never alters the state or `ext_irq` of another page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setp_valid | input | 1 | Set-pending request strobe |
| setp_page | input | PAGE_W (2) | Page of the set-pending request |
| setp_id | input | ID_W (11) | Identity to mark pending |
| reg_valid | input | 1 | Register write strobe |
| reg_page | input | PAGE_W (2) | Page addressed by read and write |
| reg_sel | input | 3 | Register select: 0 delivery, 1 threshold, 2 top interrupt, 3 pending word, 4 enable word |
| reg_word | input | WORD_W (1) | Word index for pending and enable words |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write mask |
| reg_rdata | output | 32 | Current value of the addressed register |
| ext_irq | output | NUM_PAGES (3) | External interrupt line per page |

## Verification
The assertions assume that `reg_page`, `reg_sel` and `reg_word` only matter while `reg_valid` is high, and that the set-pending fields only matter while `setp_valid` is high. The stimulus changes all inputs only on falling edges and drops the strobes after one cycle. The claim check also assumes that a set-pending on the claimed identity in the same cycle is legal and overrides the claim. The bench drives exactly that collision on purpose, and the claim assertion excludes it. Out-of-range pages, identity 0 and identities past the end are sent as ordinary traffic, so the ignore paths run under the same assertions as legal traffic.

// File: rtl/msi_pkg.sv
package msi_pkg;
  // register select codes seen on reg_sel
  typedef enum logic [2:0] {
    SEL_DELIV  = 3'd0,
    SEL_THRESH = 3'd1,
    SEL_TOP    = 3'd2,
    SEL_PEND   = 3'd3,
    SEL_ENAB   = 3'd4
  } msi_sel_e;
endpackage

// File: rtl/msi_top_encoder.sv
// Lowest-index priority encoder over an eligibility vector; index 0 never wins.
module msi_top_encoder #(
  parameter int NUM_IDS = 64,
  parameter int ID_W    = 11
) (
  input  logic [NUM_IDS-1:0] elig,
  output logic               found,
  output logic [ID_W-1:0]    win_id
);
  always_comb begin
    found  = 1'b0;
    win_id = '0;
    for (int i = NUM_IDS - 1; i >= 1; i--) begin
      if (elig[i]) begin
        found  = 1'b1;
        win_id = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/msi_elig_mask.sv
// Applies the threshold cap to the pending-and-enabled vector.
module msi_elig_mask #(
  parameter int NUM_IDS = 64,
  parameter int ID_W    = 11
) (
  input  logic [NUM_IDS-1:0] pend,
  input  logic [NUM_IDS-1:0] enab,
  input  logic [ID_W-1:0]    thresh,
  output logic [NUM_IDS-1:0] elig
);
  logic cap_on;

  assign cap_on = (thresh != '0) && ((ID_W + 1)'(thresh) <= (ID_W + 1)'(NUM_IDS));

  always_comb begin
    for (int i = 0; i < NUM_IDS; i++) begin
      elig[i] = pend[i] & enab[i] & (!cap_on || ((ID_W + 1)'(i) < (ID_W + 1)'(thresh)));
    end
  end
endmodule

// File: rtl/msi_page_state.sv
// State and register file of one page.
module msi_page_state
  import msi_pkg::*;
#(
  parameter int NUM_IDS   = 64,
  parameter int ID_W      = 11,
  parameter int XLEN      = 32,
  parameter int TOP_SHIFT = 16,
  parameter int WORD_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              set_en,
  input  logic [2:0]        sel,
  input  logic [WORD_W-1:0] word,
  input  logic [XLEN-1:0]   wdata,
  input  logic [XLEN-1:0]   wmask,
  input  logic [ID_W-1:0]   set_id,
  output logic [XLEN-1:0]   rd_data,
  output logic              irq
);
  localparam int NUM_WORDS = NUM_IDS / XLEN;
  localparam int IDX_W     = $clog2(NUM_IDS);

  msi_sel_e sel_e;
  assign sel_e = msi_sel_e'(sel);

  logic [NUM_IDS-1:0] pend_q, pend_nx;
  logic [NUM_IDS-1:0] enab_q, enab_nx;
  logic               deliv_q, deliv_nx;
  logic [ID_W-1:0]    thr_q, thr_nx;
  logic               upd_en;

  logic [NUM_IDS-1:0] elig;
  logic               top_found;
  logic [ID_W-1:0]    top_id;
  logic [XLEN-1:0]    top_val;
  logic               word_ok;
  logic [XLEN-1:0]    bit_mask;
  logic               set_ok;
  logic [IDX_W-1:0]   set_idx;
  logic [IDX_W-1:0]   top_idx;

  msi_elig_mask #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_elig (
    .pend   (pend_q),
    .enab   (enab_q),
    .thresh (thr_q),
    .elig   (elig)
  );

  msi_top_encoder #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_enc (
    .elig   (elig),
    .found  (top_found),
    .win_id (top_id)
  );

  always_comb begin
    top_val = '0;
    if (top_found) begin
      top_val[TOP_SHIFT +: ID_W] = top_id;
      top_val[ID_W-1:0]          = top_id;
    end
  end

  assign irq     = deliv_q & top_found;
  assign word_ok = (32'(word) < NUM_WORDS);
  assign set_ok  = set_en && (set_id != '0) && (32'(set_id) < NUM_IDS);
  assign set_idx = set_id[IDX_W-1:0];
  assign top_idx = top_id[IDX_W-1:0];
  assign upd_en  = wr_en | set_en;

  // identity 0 is never writable
  always_comb begin
    bit_mask = wmask;
    if (word == '0) bit_mask[0] = 1'b0;
  end

  // read path: current (pre-write) state
  always_comb begin
    rd_data = '0;
    unique case (sel_e)
      SEL_DELIV:  rd_data[0] = deliv_q;
      SEL_THRESH: rd_data[ID_W-1:0] = thr_q;
      SEL_TOP:    rd_data = top_val;
      SEL_PEND:   if (word_ok) rd_data = pend_q[32'(word) * XLEN +: XLEN];
      SEL_ENAB:   if (word_ok) rd_data = enab_q[32'(word) * XLEN +: XLEN];
      default:    rd_data = '0;
    endcase
  end

  // next state: register write first, set-pending afterwards
  always_comb begin
    pend_nx  = pend_q;
    enab_nx  = enab_q;
    deliv_nx = deliv_q;
    thr_nx   = thr_q;
    if (wr_en) begin
      unique case (sel_e)
        SEL_DELIV:  deliv_nx = (deliv_q & ~wmask[0]) | (wdata[0] & wmask[0]);
        SEL_THRESH: thr_nx = (thr_q & ~wmask[ID_W-1:0]) | (wdata[ID_W-1:0] & wmask[ID_W-1:0]);
        SEL_TOP:    if (top_found && (wmask != '0)) pend_nx[top_idx] = 1'b0;
        SEL_PEND:   if (word_ok) pend_nx[32'(word) * XLEN +: XLEN] =
                        (pend_q[32'(word) * XLEN +: XLEN] & ~bit_mask) | (wdata & bit_mask);
        SEL_ENAB:   if (word_ok) enab_nx[32'(word) * XLEN +: XLEN] =
                        (enab_q[32'(word) * XLEN +: XLEN] & ~bit_mask) | (wdata & bit_mask);
        default:    ;
      endcase
    end
    if (set_ok) pend_nx[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      enab_q  <= '0;
      deliv_q <= 1'b0;
      thr_q   <= '0;
    end else if (upd_en) begin
      pend_q  <= pend_nx;
      enab_q  <= enab_nx;
      deliv_q <= deliv_nx;
      thr_q   <= thr_nx;
    end
  end

  // R2
  set_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |=> pend_q[$past(set_idx)]);

  // R5
  claim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_e == SEL_TOP && wmask != '0 && top_found && !(set_ok && set_idx == top_idx))
    |=> !pend_q[$past(top_idx)]);

  // R3
  top_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_found |-> (top_id != '0) && pend_q[top_idx] && enab_q[top_idx]);

  // R4
  top_below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_found && thr_q != '0 && 32'(thr_q) <= NUM_IDS) |-> (top_id < thr_q));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(upd_en));

  // R12
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(pend_q) && $stable(enab_q) && $stable(thr_q) && $stable(deliv_q));
endmodule

// File: rtl/msi_file_core.sv
module msi_file_core
  import msi_pkg::*;
#(
  parameter int NUM_PAGES = 3,
  parameter int NUM_IDS   = 64,
  parameter int ID_W      = 11,
  parameter int XLEN      = 32,
  parameter int TOP_SHIFT = 16,
  localparam int NUM_WORDS = NUM_IDS / XLEN,
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES + 1) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 setp_valid,
  input  logic [PAGE_W-1:0]    setp_page,
  input  logic [ID_W-1:0]      setp_id,
  input  logic                 reg_valid,
  input  logic [PAGE_W-1:0]    reg_page,
  input  logic [2:0]           reg_sel,
  input  logic [WORD_W-1:0]    reg_word,
  input  logic [XLEN-1:0]      reg_wdata,
  input  logic [XLEN-1:0]      reg_wmask,
  output logic [XLEN-1:0]      reg_rdata,
  output logic [NUM_PAGES-1:0] ext_irq
);
  logic [XLEN-1:0] page_rd [NUM_PAGES];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic wr_hit, set_hit;
    assign wr_hit  = reg_valid  && (32'(reg_page)  == p);
    assign set_hit = setp_valid && (32'(setp_page) == p);

    msi_page_state #(
      .NUM_IDS(NUM_IDS), .ID_W(ID_W), .XLEN(XLEN),
      .TOP_SHIFT(TOP_SHIFT), .WORD_W(WORD_W)
    ) u_page (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_hit),
      .set_en  (set_hit),
      .sel     (reg_sel),
      .word    (reg_word),
      .wdata   (reg_wdata),
      .wmask   (reg_wmask),
      .set_id  (setp_id),
      .rd_data (page_rd[p]),
      .irq     (ext_irq[p])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (32'(reg_page) == p) reg_rdata = page_rd[p];
    end
  end

  // R1
  irq_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (ext_irq == '0) || rst_n);
endmodule

// File: tb/msi_file_core_bench.sv
`timescale 1ns/1ps
module msi_file_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        setp_valid;
  logic [1:0]  setp_page;
  logic [10:0] setp_id;
  logic        reg_valid;
  logic [1:0]  reg_page;
  logic [2:0]  reg_sel;
  logic [0:0]  reg_word;
  logic [31:0] reg_wdata, reg_wmask, reg_rdata;
  logic [2:0]  ext_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msi_file_core u_msi_file_core (
    .clk(clk), .rst_n(rst_n),
    .setp_valid(setp_valid), .setp_page(setp_page), .setp_id(setp_id),
    .reg_valid(reg_valid), .reg_page(reg_page), .reg_sel(reg_sel),
    .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask),
    .reg_rdata(reg_rdata), .ext_irq(ext_irq)
  );

  function automatic logic [31:0] topv(input int id);
    return (id == 0) ? 32'h0 : ((32'(id) << 16) | 32'(id));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int page, input int sel, input int word, output logic [31:0] v);
    reg_page = 2'(page); reg_sel = 3'(sel); reg_word = 1'(word);
    #1 v = reg_rdata;
  endtask

  // write; returns value seen on reg_rdata during the write cycle
  task automatic wr(input int page, input int sel, input int word,
                    input logic [31:0] d, input logic [31:0] m, output logic [31:0] old);
    @(negedge clk);
    reg_valid = 1'b1; reg_page = 2'(page); reg_sel = 3'(sel); reg_word = 1'(word);
    reg_wdata = d; reg_wmask = m;
    #1 old = reg_rdata;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic setp(input int page, input int id);
    @(negedge clk);
    setp_valid = 1'b1; setp_page = 2'(page); setp_id = 11'(id);
    @(negedge clk);
    setp_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 3; s++) begin
        rd(p, s, 0, v); chk("R1 reg after reset", v, 32'h0);
      end
      rd(p, 3, 1, v); chk("R1 pend after reset", v, 32'h0);
      rd(p, 4, 0, v); chk("R1 enab after reset", v, 32'h0);
    end
    chk("R1 irq after reset", 32'(ext_irq), 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    wr(0, 4, 0, 32'h0000_0021, 32'hFFFF_FFFF, v);  // enable 5 (bit0 ignored)
    wr(0, 4, 1, 32'h0000_0100, 32'hFFFF_FFFF, v);  // enable 40
    rd(0, 4, 0, v); chk("R9 enab id0 read-only", v, 32'h0000_0020);
    setp(0, 40);
    rd(0, 2, 0, v); chk("R3 top id40", v, topv(40));
    setp(0, 5);
    rd(0, 2, 0, v); chk("R3 lowest wins id5", v, topv(5));
    setp(0, 0);
    setp(0, 64);
    rd(0, 3, 0, v); chk("R2 id0 ignored", v, 32'h0000_0020);
    rd(0, 3, 1, v); chk("R2 id64 ignored", v, 32'h0000_0100);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    chk("R8 irq low delivery off", 32'(ext_irq[0]), 32'h0);
    wr(0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, v);
    rd(0, 0, 0, v); chk("R6 delivery bit0 only", v, 32'h1);
    chk("R8 irq high", 32'(ext_irq[0]), 32'h1);
    chk("R12 other pages quiet", 32'(ext_irq[2:1]), 32'h0);
  endtask

  task automatic t_threshold();
    logic [31:0] v;
    wr(0, 1, 0, 32'd5, 32'hFFFF_FFFF, v);
    rd(0, 2, 0, v); chk("R4 thr5 blocks 5 and 40", v, 32'h0);
    chk("R8 irq low when top zero", 32'(ext_irq[0]), 32'h0);
    wr(0, 1, 0, 32'd6, 32'hFFFF_FFFF, v);
    rd(0, 2, 0, v); chk("R4 thr6 passes 5", v, topv(5));
    wr(0, 1, 0, 32'd65, 32'hFFFF_FFFF, v);
    rd(0, 2, 0, v); chk("R4 thr65 out of range", v, topv(5));
    wr(0, 1, 0, 32'd64, 32'hFFFF_FFFF, v);
    rd(0, 2, 0, v); chk("R4 thr64 in range", v, topv(5));
    wr(0, 1, 0, 32'hFFFF_F805, 32'hFFFF_FFFF, v);
    rd(0, 1, 0, v); chk("R7 thr writable bits", v, 32'h0000_0005);
    wr(0, 1, 0, 32'h0, 32'h0000_0004, v);
    rd(0, 1, 0, v); chk("R7 thr masked write", v, 32'h0000_0001);
    wr(0, 1, 0, 32'h0, 32'hFFFF_FFFF, v);
    rd(0, 2, 0, v); chk("R4 thr0 all eligible", v, topv(5));
  endtask

  task automatic t_claim();
    logic [31:0] v;
    wr(0, 2, 0, 32'hFFFF_FFFF, 32'h0, v);
    rd(0, 2, 0, v); chk("R5 zero mask no claim", v, topv(5));
    wr(0, 2, 0, 32'h0000_1234, 32'hFFFF_FFFF, v);
    chk("R10 read during claim is old", v, topv(5));
    rd(0, 2, 0, v); chk("R5 claim 5 -> 40", v, topv(40));
    wr(0, 2, 0, 32'h0, 32'h1, v);
    rd(0, 2, 0, v); chk("R5 claim 40 -> none", v, 32'h0);
    chk("R8 irq low after claims", 32'(ext_irq[0]), 32'h0);
    wr(0, 2, 0, 32'h0, 32'hFFFF_FFFF, v);
    rd(0, 3, 0, v); chk("R5 claim with none pending", v, 32'h0);
  endtask

  task automatic t_rmw();
    logic [31:0] v;
    wr(0, 3, 0, 32'hFFFF_FFFF, 32'h0000_00F1, v);
    rd(0, 3, 0, v); chk("R9 masked set, id0 zero", v, 32'h0000_00F0);
    wr(0, 3, 0, 32'h0, 32'h0000_0030, v);
    chk("R10 read during write is old", v, 32'h0000_00F0);
    rd(0, 3, 0, v); chk("R9 masked clear", v, 32'h0000_00C0);
    wr(0, 3, 0, 32'h0, 32'hFFFF_FFFF, v);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    @(negedge clk);
    reg_valid = 1'b1; reg_page = 2'd0; reg_sel = 3'd3; reg_word = 1'b0;
    reg_wdata = 32'h0; reg_wmask = 32'hFFFF_FFFF;
    setp_valid = 1'b1; setp_page = 2'd0; setp_id = 11'd3;
    @(negedge clk);
    reg_valid = 1'b0; setp_valid = 1'b0;
    rd(0, 3, 0, v); chk("R11 set wins over clear", v, 32'h0000_0008);
    wr(0, 4, 0, 32'h8, 32'h8, v);
    // claim of id 3 while id 3 is set again in the same cycle
    @(negedge clk);
    reg_valid = 1'b1; reg_sel = 3'd2; reg_wmask = 32'hFFFF_FFFF;
    setp_valid = 1'b1; setp_id = 11'd3;
    @(negedge clk);
    reg_valid = 1'b0; setp_valid = 1'b0;
    rd(0, 2, 0, v); chk("R11 set wins over claim", v, topv(3));
    chk("R8 irq follows new top", 32'(ext_irq[0]), 32'h1);
  endtask

  task automatic t_pages();
    logic [31:0] v;
    wr(1, 4, 0, 32'h80, 32'hFFFF_FFFF, v);
    setp(1, 7);
    wr(1, 0, 0, 32'h1, 32'h1, v);
    rd(1, 2, 0, v); chk("R12 page1 top", v, topv(7));
    chk("R12 irq per page", 32'(ext_irq), 32'b011);
    rd(0, 2, 0, v); chk("R12 page0 untouched", v, topv(3));
    setp(3, 9);
    wr(3, 3, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, v);
    rd(3, 3, 0, v); chk("R10 page out of range reads 0", v, 32'h0);
    rd(2, 3, 0, v); chk("R2 page out of range ignored", v, 32'h0);
    rd(0, 3, 0, v); chk("R2 page0 unaffected", v, 32'h0000_0008);
    rd(0, 7, 0, v); chk("R10 unused select reads 0", v, 32'h0);
    chk("R12 irq page2 low", 32'(ext_irq[2]), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; setp_valid = 1'b0; setp_page = '0; setp_id = '0;
    reg_valid = 1'b0; reg_page = '0; reg_sel = '0; reg_word = '0;
    reg_wdata = '0; reg_wmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_irq();
    t_threshold();
    t_claim();
    t_rmw();
    t_same_cycle();
    t_pages();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule